// File: doc/BRIEF.md
# Flow-Controlled Elastic Byte Stream Buffer

This block is a single-clock byte FIFO that sits between a host-bus decoder and user logic. One instance is used for each direction of a byte stream. The producer side writes bytes qualified by a write strobe. A flow-control output asks for more data for as long as the buffer is less than half full. The producer is expected to slow down once that signal drops.

The consumer side works in first-word-fall-through form. Whenever the buffer holds data, the oldest byte is already on the output port, before any request is made. The consumer checks the empty flag and then raises a request. A request that finds data pops the byte and is answered in the same cycle by a consume strobe, so the consumer captures the byte on the clock edge where the strobe is high. A request made against an empty buffer gets no strobe and changes nothing.

Storage is a simple dual-port memory with a registered read port, so it maps to block RAM. A small bypass register keeps the head byte valid when a byte is written into the location that is about to become the head.

Top module: `esb_stream_buf`

## Requirements
- R1: While the occupancy is non-zero, `out_byte` carries the oldest unread byte in every cycle, whether or not `out_req` is high.
- R2: When `out_req` is high and `out_empty` is low, `out_stb` is high in that same cycle, `out_byte` is the byte consumed at the next rising edge, and the following byte becomes the head.
- R3: When `out_req` is high and `out_empty` is high, `out_stb` stays low, and a later read returns the bytes in unchanged write order.
- R4: A byte on `in_byte` is captured at a rising edge only when `in_stb` is high; with `in_stb` low, no byte enters the buffer.
- R5: `in_want` is 1 exactly when the occupancy after the last edge is less than DEPTH/2 (1024 with defaults), and 0 otherwise.
- R6: `out_empty` is 1 exactly when the occupancy after the last edge is zero.
- R7: A write while the occupancy is DEPTH (2048 with defaults) is dropped, even if a read happens in the same cycle. Occupancy does not rise, and the stored bytes are unchanged.
- R8: A successful read together with an accepted write in the same cycle leaves the occupancy unchanged.
- R9: While `rst` is high at a rising edge, the buffer is emptied and both pointers are cleared. After that edge, `out_empty` is 1, `in_want` is 1, and `out_stb` is low for any `out_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all ports are synchronous to its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_stb | input | 1 | Write qualifier for `in_byte` |
| in_byte | input | DW (8) | Byte written into the buffer |
| in_want | output | 1 | High while occupancy is below half of capacity |
| out_req | input | 1 | Request to consume the head byte |
| out_byte | output | DW (8) | Head byte (first-word-fall-through) |
| out_stb | output | 1 | High in the cycle a requested byte is consumed |
| out_empty | output | 1 | High when the buffer holds no byte |

## Verification
The assertions take for granted that `rst` is held for at least one rising edge before any traffic. They also take `out_req` and `in_stb` to be plain levels that are sampled at the rising edge, with no requirement that they follow `out_empty` or `in_want`. The stimulus therefore changes inputs only on falling edges. It deliberately ignores the flow-control signals: it issues reads against an empty buffer and writes against a full one, so the dropped-write and refused-read paths are exercised rather than avoided. The mixed random phase mostly stays below half capacity. A dedicated phase then fills the buffer to its limit and beyond before draining it.

// File: rtl/esb_pkg.sv
package esb_pkg;
  parameter int unsigned ESB_DW = 8;
  parameter int unsigned ESB_AW = 11;

  function automatic int unsigned esb_half(input int unsigned aw);
    return (1 << aw) / 2;
  endfunction
endpackage

// File: rtl/esb_ram.sv
module esb_ram #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/esb_ctrl.sv
module esb_ctrl #(
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_req,
  output logic          push,
  output logic          pop,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_addr_n,
  output logic          empty,
  output logic          want
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned HALF  = esb_pkg::esb_half(AW);
  localparam int unsigned CW    = AW + 1;

  logic [CW-1:0] cnt, cnt_n;
  logic [AW-1:0] rd_ptr;
  logic          full;

  assign push      = wr_en && !full;
  assign pop       = rd_req && !empty;
  assign rd_addr_n = pop ? rd_ptr + AW'(1) : rd_ptr;
  assign cnt_n     = cnt + CW'(push) - CW'(pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
      empty  <= 1'b1;
      full   <= 1'b0;
      want   <= 1'b1;
    end else begin
      cnt    <= cnt_n;
      rd_ptr <= rd_addr_n;
      if (push) wr_ptr <= wr_ptr + AW'(1);
      empty  <= (cnt_n == '0);
      full   <= (cnt_n == CW'(DEPTH));
      want   <= (cnt_n < CW'(HALF));
    end
  end

  // R2
  rd_adv_chk: assert property (@(posedge clk) disable iff (rst)
    pop |=> rd_ptr == AW'($past(rd_ptr) + AW'(1)));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && empty) |=> rd_ptr == $past(rd_ptr));

  // R5
  want_level_chk: assert property (@(posedge clk) disable iff (rst)
    want == (cnt < CW'(HALF)));

  // R6
  empty_level_chk: assert property (@(posedge clk) disable iff (rst)
    empty == (cnt == '0));

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |=> cnt <= $past(cnt));

  // R8
  same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> cnt == $past(cnt));

  // R9
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (empty && want && cnt == '0 && rd_ptr == '0 && wr_ptr == '0));
endmodule

// File: rtl/esb_stream_buf.sv
module esb_stream_buf #(
  parameter int unsigned DW = esb_pkg::ESB_DW,
  parameter int unsigned AW = esb_pkg::ESB_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_stb,
  input  logic [DW-1:0] in_byte,
  output logic          in_want,
  input  logic          out_req,
  output logic [DW-1:0] out_byte,
  output logic          out_stb,
  output logic          out_empty
);
  logic          push, pop;
  logic [AW-1:0] wr_ptr, rd_addr_n;
  logic [DW-1:0] ram_q, byp_d;
  logic          byp_q;

  esb_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(in_stb), .rd_req(out_req),
    .push(push), .pop(pop), .wr_ptr(wr_ptr), .rd_addr_n(rd_addr_n),
    .empty(out_empty), .want(in_want)
  );

  esb_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk(clk), .we(push), .waddr(wr_ptr), .wdata(in_byte),
    .raddr(rd_addr_n), .rdata(ram_q)
  );

  // Write landing on the next head location: RAM read is stale, bypass it.
  always_ff @(posedge clk) begin
    if (rst) begin
      byp_q <= 1'b0;
      byp_d <= '0;
    end else begin
      byp_q <= push && (wr_ptr == rd_addr_n);
      byp_d <= in_byte;
    end
  end

  assign out_byte = byp_q ? byp_d : ram_q;
  assign out_stb  = pop;

  // R3
  no_stb_empty_chk: assert property (@(posedge clk) disable iff (rst)
    out_empty |-> !out_stb);

  // R4
  idle_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_stb && !out_req && !out_empty) |=> !out_empty && $stable(out_byte));
endmodule

// File: tb/esb_stream_buf_test.sv
module esb_stream_buf_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;
  localparam int HALF = DEPTH / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_stb = 1'b0;
  logic [DW-1:0] in_byte = '0;
  logic out_req = 1'b0;
  logic in_want, out_stb, out_empty;
  logic [DW-1:0] out_byte;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  byte unsigned sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  esb_stream_buf #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .rst(rst), .in_stb(in_stb), .in_byte(in_byte), .in_want(in_want),
    .out_req(out_req), .out_byte(out_byte), .out_stb(out_stb), .out_empty(out_empty)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver + monitor for one cycle: drive at falling edge, compare, update scoreboard.
  task automatic step(input bit wr, input byte unsigned wd, input bit rd);
    int occ;
    bit exp_stb;
    @(negedge clk);
    in_stb = wr; in_byte = wd; out_req = rd;
    #1;
    occ = sb.size();
    exp_stb = rd && (occ > 0);
    chk(out_empty == (occ == 0), "R6 empty flag", out_empty, occ == 0);
    chk(in_want == (occ < HALF), "R5 want level", in_want, occ < HALF);
    chk(out_stb == exp_stb, rd && occ == 0 ? "R3 no strobe on empty" : "R2 strobe", out_stb, exp_stb);
    if (occ > 0)
      chk(out_byte == sb[0], "R1 head byte", out_byte, sb[0]);
    if (exp_stb) void'(sb.pop_front());
    if (wr && occ < DEPTH) sb.push_back(wd);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_stb = 1'b0; out_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    sb.delete();
    #1;
    chk(out_empty == 1'b1, "R9 reset empty", out_empty, 1);
    chk(in_want == 1'b1, "R9 reset want", in_want, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9 / R3: request against an empty buffer after reset
    step(0, 8'h00, 1);
    chk(out_stb == 1'b0, "R9 no strobe after reset", out_stb, 0);

    // R4: strobe low must not write
    step(0, 8'hEE, 0);
    step(0, 8'hEE, 0);
    chk(out_empty == 1'b1, "R4 ignored write", out_empty, 1);

    // R1: head visible with no request
    step(1, 8'hA1, 0);
    step(1, 8'hB2, 0);
    step(1, 8'hC3, 0);
    step(0, 8'h00, 0);
    chk(out_byte == 8'hA1, "R1 head before request", out_byte, 8'hA1);

    // R8: read and write together keep occupancy
    step(1, 8'hD4, 1);
    step(1, 8'hE5, 1);
    chk(sb.size() == 3, "R8 occupancy model", sb.size(), 3);
    step(0, 8'h00, 0);
    chk(out_empty == 1'b0, "R8 not empty", out_empty, 0);

    // R2: drain back to back, then R3 read on empty
    repeat (4) step(0, 8'h00, 1);
    step(0, 8'h00, 1);
    chk(out_empty == 1'b1, "R3 empty after drain", out_empty, 1);

    // Write into empty and consume in the next cycle (bypass path)
    step(1, 8'h5A, 0);
    step(1, 8'h6B, 1);
    step(0, 8'h00, 1);
    step(0, 8'h00, 0);

    // Mixed random traffic
    for (int i = 0; i < 3000; i++)
      step(($urandom % 3) != 0, 8'($urandom), ($urandom % 2) == 0);
    while (sb.size() > 0) step(0, 8'h00, 1);

    // R5: threshold at half capacity
    for (int i = 0; i < HALF - 1; i++) step(1, 8'(i * 7 + 3), 0);
    step(0, 8'h00, 0);
    chk(in_want == 1'b1, "R5 want just below half", in_want, 1);
    step(1, 8'h77, 0);
    step(0, 8'h00, 0);
    chk(in_want == 1'b0, "R5 want at half", in_want, 0);

    // R7: fill to capacity and keep writing
    while (sb.size() < DEPTH) step(1, 8'($urandom), 0);
    repeat (5) step(1, 8'hFF, 0);
    chk(sb.size() == DEPTH, "R7 model capacity", sb.size(), DEPTH);
    step(1, 8'hFE, 1);
    chk(sb.size() == DEPTH - 1, "R7 write dropped with read at full", sb.size(), DEPTH - 1);
    while (sb.size() > 0) step(0, 8'h00, 1);
    step(0, 8'h00, 0);
    chk(out_empty == 1'b1, "R7 exact drain count", out_empty, 1);

    // R9: reset with data held
    step(1, 8'h11, 0);
    step(1, 8'h22, 0);
    do_reset();
    step(0, 8'h00, 1);
    chk(out_stb == 1'b0, "R9 no strobe after mid-run reset", out_stb, 0);
    step(1, 8'h33, 0);
    step(0, 8'h00, 1);
    step(0, 8'h00, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule